// File: doc/BRIEF.md
# Status Silo Byte Reader

This block holds a short queue of three 16-bit words that a controller produces when a drive command completes. A host reads the queue through an 8-bit path. Each pulse on a single read strobe returns one byte. A side pointer alternates between the low and the high half of the front word. The queue advances only after the high half has been taken, so each 16-bit word is read as a low byte followed by a high byte.

The queue is filled in one of two ways. When a status fetch completes, the controller presents one drive status word and it is copied into every entry. When a header read completes, the controller presents the cylinder, head and sector. The block packs these into one word in the front entry and zeroes the two entries behind it. Whenever the host writes a new command word, the side pointer returns to the low half. The status bits themselves are produced elsewhere.

Top module: `stat_silo_reader`

## Requirements
- R1: A synchronous active-high reset sets all three entries to zero, sets the side pointer to the low half and sets rd_byte to zero.
- R2: An accepted read strobe returns bits 7:0 of the front entry when the side pointer is low and bits 15:8 when it is high. The value appears on rd_byte one cycle after the strobe and is held until the next accepted strobe. Each accepted strobe toggles the pointer. A strobe is accepted only when stat_load, hdr_load and cmd_wr are all low in the same cycle.
- R3: After an accepted high-half read, the second entry moves to the front and the third entry moves to second. The third entry keeps its old value.
- R4: An accepted low-half read leaves all entries unchanged, so the following high-half read comes from the same word.
- R5: cmd_wr returns the side pointer to the low half. A read strobe in the same cycle as cmd_wr is ignored.
- R6: stat_load copies stat_word into all three entries.
- R7: hdr_load writes ((hdr_cyl*2 + hdr_head) << 6) | hdr_sect into the front entry and zeroes the other two. The sector occupies bits 5:0 and the track number occupies bits 15:6.
- R8: When a load and a read strobe arrive in the same cycle, the load takes effect and the strobe is ignored, so both rd_byte and the pointer stay unchanged. A load on its own does not move the pointer.
- R9: When stat_load and hdr_load are both high, the status load wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | New command word written; returns the pointer to the low half |
| stat_load | input | 1 | Status fetch complete; copy stat_word into all entries |
| stat_word | input | 16 | Drive status word |
| hdr_load | input | 1 | Header read complete; load the packed header word |
| hdr_cyl | input | 9 | Cylinder for the header word |
| hdr_head | input | 1 | Head (surface) for the header word |
| hdr_sect | input | 6 | Sector for the header word |
| rd_stb | input | 1 | Read strobe from the host |
| rd_byte | output | 8 | Byte returned by the last accepted strobe |

## Verification
The assertions assume that every control input is a clean single-cycle level sampled at the clock, with no X once reset is released. They also assume that a load or a command write can coincide with a strobe, in which case the strobe is ignored. The bench changes every input only on the falling edge and holds it across one rising edge. It deliberately produces each coincidence the assertions allow: a load with a strobe, a command write with a strobe, and both loads together. The expected bytes come from a reference model of the queue, built from the requirements, and a monitor compares them one cycle after each accepted strobe.

// File: rtl/silo_pkg.sv
package silo_pkg;
  typedef enum logic {SIDE_LO = 1'b0, SIDE_HI = 1'b1} side_e;
endpackage

// File: rtl/silo_ptr.sv
module silo_ptr
  import silo_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clr,
  input  logic  adv,
  output side_e side_q
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      side_q <= SIDE_LO;
    else if (adv)
      side_q <= (side_q == SIDE_HI) ? SIDE_LO : SIDE_HI;
  end

  a_r1_ptr_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> side_q == SIDE_LO);
  a_r5_cmd_clears: assert property (@(posedge clk) disable iff (rst)
    clr |=> side_q == SIDE_LO);
  a_r2_toggle: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr) |=> side_q != $past(side_q));
endmodule

// File: rtl/silo_hdr_fmt.sv
module silo_hdr_fmt #(
  parameter int ENTRY_W = 16,
  parameter int CYL_W   = 9,
  parameter int SECT_W  = 6
) (
  input  logic [CYL_W-1:0]   cyl,
  input  logic               head,
  input  logic [SECT_W-1:0]  sect,
  output logic [ENTRY_W-1:0] word
);
  localparam int TRK_W = CYL_W + 1;
  localparam int RAW_W = TRK_W + SECT_W;

  logic [TRK_W-1:0] trk;
  assign trk = {cyl, head};   // cylinder*2 + head

  generate
    if (RAW_W == ENTRY_W) begin : g_exact
      assign word = {trk, sect};
    end else begin : g_pad
      assign word = {{(ENTRY_W-RAW_W){1'b0}}, trk, sect};
    end
  endgenerate

  initial assert (RAW_W <= ENTRY_W) else $error("header fields exceed entry width");
endmodule

// File: rtl/silo_queue.sv
module silo_queue #(
  parameter int DEPTH   = 3,
  parameter int ENTRY_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_all,
  input  logic [ENTRY_W-1:0] all_word,
  input  logic               ld_head,
  input  logic [ENTRY_W-1:0] head_word,
  input  logic               shift,
  output logic [ENTRY_W-1:0] head_q
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0][ENTRY_W-1:0] ent_q, ent_d;

  always_comb begin
    ent_d = ent_q;
    if (ld_all) begin
      for (int i = 0; i < DEPTH; i++) ent_d[i] = all_word;
    end else if (ld_head) begin
      for (int i = 0; i < DEPTH; i++) ent_d[i] = '0;
      ent_d[0] = head_word;
    end else if (shift) begin
      for (int i = 0; i < LAST; i++) ent_d[i] = ent_q[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ent_q <= '0;
    else     ent_q <= ent_d;
  end

  assign head_q = ent_q[0];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
      a_r1_entry_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ent_q[g] == '0);
      a_r6_load_all: assert property (@(posedge clk) disable iff (rst)
        ld_all |=> ent_q[g] == $past(all_word));
      a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!ld_all && !ld_head && !shift) |=> $stable(ent_q[g]));
      if (g == 0) begin : g_front
        a_r7_head_load: assert property (@(posedge clk) disable iff (rst)
          (ld_head && !ld_all) |=> ent_q[0] == $past(head_word));
      end else begin : g_back
        a_r7_tail_zero: assert property (@(posedge clk) disable iff (rst)
          (ld_head && !ld_all) |=> ent_q[g] == '0);
      end
      if (g < LAST) begin : g_move
        a_r3_ripple: assert property (@(posedge clk) disable iff (rst)
          (shift && !ld_all && !ld_head) |=> ent_q[g] == $past(ent_q[g+1]));
      end else begin : g_keep
        a_r3_tail_keep: assert property (@(posedge clk) disable iff (rst)
          (shift && !ld_all && !ld_head) |=> $stable(ent_q[g]));
      end
    end
  endgenerate
endmodule

// File: rtl/stat_silo_reader.sv
module stat_silo_reader
  import silo_pkg::*;
#(
  parameter int DEPTH   = 3,
  parameter int BYTE_W  = 8,
  parameter int CYL_W   = 9,
  parameter int SECT_W  = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_wr,
  input  logic                stat_load,
  input  logic [2*BYTE_W-1:0] stat_word,
  input  logic                hdr_load,
  input  logic [CYL_W-1:0]    hdr_cyl,
  input  logic                hdr_head,
  input  logic [SECT_W-1:0]   hdr_sect,
  input  logic                rd_stb,
  output logic [BYTE_W-1:0]   rd_byte
);
  localparam int ENTRY_W = 2 * BYTE_W;

  side_e              side_q;
  logic               accept, shift;
  logic [ENTRY_W-1:0] hdr_word, head_q;

  assign accept = rd_stb && !stat_load && !hdr_load && !cmd_wr;
  assign shift  = accept && (side_q == SIDE_HI);

  silo_hdr_fmt #(.ENTRY_W(ENTRY_W), .CYL_W(CYL_W), .SECT_W(SECT_W)) u_fmt (
    .cyl (hdr_cyl), .head(hdr_head), .sect(hdr_sect), .word(hdr_word)
  );

  silo_ptr u_ptr (
    .clk(clk), .rst(rst), .clr(cmd_wr), .adv(accept), .side_q(side_q)
  );

  silo_queue #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_q (
    .clk(clk), .rst(rst),
    .ld_all(stat_load), .all_word(stat_word),
    .ld_head(hdr_load), .head_word(hdr_word),
    .shift(shift), .head_q(head_q)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rd_byte <= '0;
    else if (accept)
      rd_byte <= (side_q == SIDE_HI) ? head_q[ENTRY_W-1 -: BYTE_W] : head_q[BYTE_W-1:0];
  end

  a_r1_byte_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> rd_byte == '0);
  a_r8_strobe_blocked: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && (stat_load || hdr_load || cmd_wr)) |=> $stable(rd_byte));
  a_r8_load_keeps_side: assert property (@(posedge clk) disable iff (rst)
    ((stat_load || hdr_load) && !cmd_wr) |=> $stable(side_q));
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_byte));
endmodule

// File: tb/test_stat_silo_reader.sv
`timescale 1ns/1ps
module test_stat_silo_reader;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_wr = 1'b0, stat_load = 1'b0, hdr_load = 1'b0, rd_stb = 1'b0;
  logic [15:0] stat_word = '0;
  logic [8:0]  hdr_cyl = '0;
  logic        hdr_head = 1'b0;
  logic [5:0]  hdr_sect = '0;
  logic [7:0]  rd_byte;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [7:0]  exp_q[$];
  string       tag_q[$];
  logic [15:0] m [3];
  bit          m_side;
  logic        took = 1'b0;

  always #2.5 clk = ~clk;

  stat_silo_reader i_stat_silo_reader (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .stat_load(stat_load),
    .stat_word(stat_word), .hdr_load(hdr_load), .hdr_cyl(hdr_cyl),
    .hdr_head(hdr_head), .hdr_sect(hdr_sect), .rd_stb(rd_stb), .rd_byte(rd_byte)
  );

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_byte=%02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: compare one cycle after each accepted strobe
  always @(posedge clk) took <= rd_stb && !stat_load && !hdr_load && !cmd_wr && !rst;
  always @(negedge clk) begin
    if (took) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected byte %02h expected none", rd_byte);
      end else begin
        check8(rd_byte, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  // driver: one cycle of stimulus, with the reference model updated per requirements
  task automatic drive(input bit st, input logic [15:0] w, input bit hd,
                       input logic [8:0] cyl, input bit h, input logic [5:0] sec,
                       input bit cm, input bit rs, input string tag);
    @(negedge clk);
    stat_load = st; stat_word = w; hdr_load = hd;
    hdr_cyl = cyl; hdr_head = h; hdr_sect = sec; cmd_wr = cm; rd_stb = rs;
    if (rs && !st && !hd && !cm) begin
      exp_q.push_back(m_side ? m[0][15:8] : m[0][7:0]);
      tag_q.push_back(tag);
      if (m_side) begin m[0] = m[1]; m[1] = m[2]; end
      m_side = !m_side;
    end
    if (cm) m_side = 0;
    if (st) begin
      for (int i = 0; i < 3; i++) m[i] = w;
    end else if (hd) begin
      m[0] = {cyl, h, sec}; m[1] = '0; m[2] = '0;
    end
  endtask

  task automatic idle();
    drive(0, '0, 0, '0, 0, '0, 0, 0, "");
  endtask
  task automatic rd(input string tag);
    drive(0, '0, 0, '0, 0, '0, 0, 1, tag);
  endtask
  task automatic cmd();
    drive(0, '0, 0, '0, 0, '0, 1, 0, "");
  endtask
  task automatic ld_stat(input logic [15:0] w);
    drive(1, w, 0, '0, 0, '0, 0, 0, "");
  endtask
  task automatic ld_hdr(input logic [8:0] c, input bit h, input logic [5:0] s);
    drive(0, '0, 1, c, h, s, 0, 0, "");
  endtask

  initial begin
    logic [7:0] held;
    for (int i = 0; i < 3; i++) m[i] = '0;
    m_side = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check8(rd_byte, 8'h00, "R1 reset byte");
    rd("R1 zero entry lo"); rd("R1 zero entry hi");

    // status fetch fills all entries; four words expose tail keep
    ld_stat(16'hA5C3);
    for (int k = 0; k < 4; k++) begin
      rd("R2 R4 status lo"); rd("R3 status hi");
    end

    // command write resets side pointer
    ld_stat(16'h1234);
    rd("R2 lo before cmd"); cmd(); rd("R5 lo after cmd"); rd("R2 hi");
    // command with strobe: strobe ignored
    rd("R2 lo"); idle(); held = rd_byte;
    drive(0, '0, 0, '0, 0, '0, 1, 1, "");
    idle();
    check8(rd_byte, held, "R5 strobe with cmd ignored");
    rd("R5 lo after cmd+strobe");

    // header reads
    cmd(); ld_hdr(9'd171, 1'b0, 6'd5);
    rd("R7 hdr lo"); rd("R7 hdr hi");
    rd("R7 tail lo zero"); rd("R7 tail hi zero"); rd("R7 third lo"); rd("R7 third hi");
    cmd(); ld_hdr(9'd511, 1'b1, 6'd39);
    rd("R7 max hdr lo"); rd("R7 max hdr hi");

    // load with strobe: load wins, pointer unchanged (left on high side)
    cmd(); ld_stat(16'h0F0F); rd("R2 lo"); idle(); held = rd_byte;
    drive(1, 16'hBEEF, 0, '0, 0, '0, 0, 1, "");
    idle();
    check8(rd_byte, held, "R8 strobe with load ignored");
    rd("R8 hi of new word"); rd("R8 lo next");
    drive(0, '0, 1, 9'd3, 1'b1, 6'd2, 0, 1, "");
    idle();
    rd("R8 hi after hdr load");

    // both loads together: status wins
    cmd(); drive(1, 16'h5A69, 1, 9'd7, 1'b0, 6'd1, 0, 0, "");
    rd("R9 lo"); rd("R9 hi"); rd("R9 second lo"); rd("R9 second hi");
    idle(); idle();

    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2: %0d bytes missing expected 0", exp_q.size());
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule